// File: doc/BRIEF.md
# Wake Event Status Register

This block gathers the wake and interrupt sources of a power-management unit into one bank of sticky status bits. Each source has its own qualification rule:
- Some sources are plain requests from on-chip logic, and their bits latch while the request is high.
- The ring-indicate pin and the thermal alarm pin pass through synchronisers, and their bits latch only on the edge into the active level.
- The audio-codec bit latches when codec serial data stays high after the codec bit clock has stopped. It also latches when the codec global interrupt is raised.
- The standby-timer bit latches only while the platform sleep state is S1.

Software reads the status word and clears bits by writing ones to them. Software also programs an enable word. A single power-management event output is the OR of every status bit that is both enabled and allowed to raise an event. The SMBus wake bit and the thermal override bit are recorded but never raise the event.

The register port is one address bit wide. Address 0 selects the status word, and address 1 selects the enable word. Writes take effect on the next clock edge. Reads are combinational.

Top module: `wake_status_reg`

## Requirements
- R1: After reset, the status word reads 0, the enable word reads 0 and `pmEvent` is low.
- R2: Status bit positions are: ring 0, SMBus 1, reserved 2, TCO 3, codec 4, USB lane 0 at 5, USB lane 1 at 6, standby 7, thermal 8, thermal override 9. A write to address 0 clears each bit whose data bit is 1 and leaves bits written with 0 unchanged. Bit 2 always reads 0.
- R3: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R4: The ring bit sets when the synchronised active-low ring input falls. Holding the input low does not set the bit again after it has been cleared.
- R5: A high `smbWakeReq` sets bit 1. Bit 1 never drives `pmEvent`, and enable bit 1 always reads 0.
- R6: A high `tcoSciReq` sets bit 3. Bit 3 raises `pmEvent` when enable bit 3 is 1.
- R7: The codec bit sets when either codec data input is high while the bit clock has shown no edge for `BCLK_TIMEOUT` clock cycles. It does not set while the bit clock keeps toggling. A high `codecGlobalInt` also sets it.
- R8: `usbWakeReq[k]` sets bit 5+k. That bit raises `pmEvent` only when its own enable bit is 1.
- R9: A high `standbyTimeout` sets bit 7 only when `sleepState` equals 1 (S1). Any other sleep state leaves the bit unchanged.
- R10: The thermal bit sets on the transition of `thermPin` into its active level. The active level is high when `thermPolHigh` is 1 and low when it is 0. Holding the pin at the active level does not set the bit again.
- R11: A high `thermOverride` sets bit 9. Bit 9 never drives `pmEvent`, and enable bit 9 always reads 0.
- R12: A write to address 1 loads the enable word, masked to the event-capable bits 0, 3, 4, 5, 6, 7 and 8. `pmEvent` equals the OR of status AND enable over those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 1 | Register select: 0 status, 1 enable |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 10 | Write data |
| regRdData | output | 10 | Read data of the selected register |
| ringInN | input | 1 | Asynchronous active-low ring indicate |
| smbWakeReq | input | 1 | SMBus wake request |
| tcoSciReq | input | 1 | Watchdog/TCO SCI request |
| codecSdin | input | 2 | Codec serial data inputs (asynchronous) |
| codecBitClk | input | 1 | Codec bit clock (asynchronous) |
| codecGlobalInt | input | 1 | Codec global interrupt |
| usbWakeReq | input | 2 | USB wake requests, one per controller |
| standbyTimeout | input | 1 | Standby timer timeout |
| sleepState | input | 3 | Current sleep state code |
| thermPin | input | 1 | Asynchronous thermal alarm pin |
| thermPolHigh | input | 1 | Thermal active level select (1 = high) |
| thermOverride | input | 1 | Thermal override throttling started |
| pmEvent | output | 1 | Power-management event |

## Verification
The bench builds the block with `BCLK_TIMEOUT` set to 8. At that value the codec idle window can be reached in about ten cycles, so the bench can probe both sides of the window in one short run. The 10-bit register width makes full sweeps affordable:
- all 1024 clear masks are applied against a fully set status word;
- all 1024 enable words are applied, each checked for its readback and its event;
- all eight sleep-state codes are tried against the timer timeout.

Every expected value is computed from the bit positions given in the requirements.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int STAT_W = 10;

  localparam int B_RING  = 0;
  localparam int B_SMB   = 1;
  localparam int B_RSVD  = 2;
  localparam int B_TCO   = 3;
  localparam int B_CODEC = 4;
  localparam int B_USB0  = 5;
  localparam int B_USB1  = 6;
  localparam int B_STBY  = 7;
  localparam int B_THERM = 8;
  localparam int B_TOVR  = 9;

  localparam int USB_LANES = 2;

  // bits that physically exist (reserved bit removed)
  localparam logic [STAT_W-1:0] IMPL_MASK = ~(STAT_W'(1) << B_RSVD);

  // bits allowed to raise the power-management event
  localparam logic [STAT_W-1:0] EVT_CAP_MASK =
      (STAT_W'(1) << B_RING)  | (STAT_W'(1) << B_TCO)  |
      (STAT_W'(1) << B_CODEC) | (STAT_W'(1) << B_USB0) |
      (STAT_W'(1) << B_USB1)  | (STAT_W'(1) << B_STBY) |
      (STAT_W'(1) << B_THERM);

  localparam logic [2:0] SLEEP_S1 = 3'd1;

  typedef struct packed {
    logic [STAT_W-1:0] setMask;     // hardware set requests, one per bit
    logic              clrStatus;   // write-one-to-clear strobe
    logic              loadEnable;  // enable register load strobe
    logic              rdSelEnable; // read mux select
  } ctrlStrobes_t;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chainQ[s] <= RST_VAL;
    end else begin
      chainQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chainQ[s] <= chainQ[s-1];
    end
  end

  assign syncOut = chainQ[STAGES-1];

endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int BCLK_TIMEOUT = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regAddr,
  input  logic                 regWrEn,
  input  logic                 ringInN,
  input  logic                 smbWakeReq,
  input  logic                 tcoSciReq,
  input  logic [1:0]           codecSdin,
  input  logic                 codecBitClk,
  input  logic                 codecGlobalInt,
  input  logic [USB_LANES-1:0] usbWakeReq,
  input  logic                 standbyTimeout,
  input  logic [2:0]           sleepState,
  input  logic                 thermPin,
  input  logic                 thermPolHigh,
  input  logic                 thermOverride,
  output ctrlStrobes_t         strobes
);

  localparam int CNT_W  = $clog2(BCLK_TIMEOUT + 1);
  localparam int ASYNC_W = 5;
  // order: {ring, therm, bitclk, sdin[1:0]}; ring idles high
  localparam logic [ASYNC_W-1:0] ASYNC_RST = 5'b10000;

  logic [ASYNC_W-1:0] syncVec;
  logic               ringSync, thermSync, bclkSync;
  logic [1:0]         sdinSync;

  wake_sync #(
    .WIDTH  (ASYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(ASYNC_RST)
  ) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({ringInN, thermPin, codecBitClk, codecSdin}),
    .syncOut(syncVec)
  );

  assign {ringSync, thermSync, bclkSync, sdinSync} = syncVec;

  // edge history
  logic ringPrevQ, thermActPrevQ, bclkPrevQ;
  logic thermActive;
  logic ringFall, thermRise, bclkEdge;

  assign thermActive = (thermSync == thermPolHigh);
  assign ringFall    = ringPrevQ & ~ringSync;
  assign thermRise   = thermActive & ~thermActPrevQ;
  assign bclkEdge    = bclkSync ^ bclkPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringPrevQ     <= 1'b1;
      thermActPrevQ <= 1'b1;
      bclkPrevQ     <= 1'b0;
    end else begin
      ringPrevQ     <= ringSync;
      thermActPrevQ <= thermActive;
      bclkPrevQ     <= bclkSync;
    end
  end

  // bit clock idle watchdog
  logic [CNT_W-1:0] idleCntQ;
  logic             bclkStopped;

  assign bclkStopped = (idleCntQ == CNT_W'(BCLK_TIMEOUT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCntQ <= '0;
    end else if (bclkEdge) begin
      idleCntQ <= '0;
    end else if (!bclkStopped) begin
      idleCntQ <= idleCntQ + CNT_W'(1);
    end
  end

  logic codecWake;
  assign codecWake = (bclkStopped & (|sdinSync)) | codecGlobalInt;

  always_comb begin
    strobes                 = '0;
    strobes.setMask[B_RING]  = ringFall;
    strobes.setMask[B_SMB]   = smbWakeReq;
    strobes.setMask[B_TCO]   = tcoSciReq;
    strobes.setMask[B_CODEC] = codecWake;
    strobes.setMask[B_USB0]  = usbWakeReq[0];
    strobes.setMask[B_USB1]  = usbWakeReq[1];
    strobes.setMask[B_STBY]  = standbyTimeout & (sleepState == SLEEP_S1);
    strobes.setMask[B_THERM] = thermRise;
    strobes.setMask[B_TOVR]  = thermOverride;
    strobes.clrStatus        = regWrEn & ~regAddr;
    strobes.loadEnable       = regWrEn & regAddr;
    strobes.rdSelEnable      = regAddr;
  end

  AST_RING_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setMask[B_RING] |=> !strobes.setMask[B_RING]); // R4

  AST_THERM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setMask[B_THERM] |=> !strobes.setMask[B_THERM]); // R10

  AST_CODEC_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setMask[B_CODEC] && !codecGlobalInt) |-> !$past(bclkEdge)); // R7

endmodule

// File: rtl/wake_dp.sv
module wake_dp
  import wake_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] rdData,
  output logic              pmEvent
);

  logic [STAT_W-1:0] statusQ, statusNext;
  logic [STAT_W-1:0] enableQ, enableNext;
  logic [STAT_W-1:0] clrMask;

  assign clrMask = strobes.clrStatus ? wrData : '0;

  // per-bit variant: reserved/non-capable bits are tied off
  for (genvar i = 0; i < STAT_W; i++) begin : gBit
    if (IMPL_MASK[i]) begin : gStat
      assign statusNext[i] = strobes.setMask[i] | (statusQ[i] & ~clrMask[i]);
    end else begin : gStatRsvd
      assign statusNext[i] = 1'b0;
    end
    if (EVT_CAP_MASK[i]) begin : gEn
      assign enableNext[i] = strobes.loadEnable ? wrData[i] : enableQ[i];
    end else begin : gEnNone
      assign enableNext[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusNext;
      enableQ <= enableNext;
    end
  end

  assign rdData  = strobes.rdSelEnable ? enableQ : statusQ;
  assign pmEvent = |(statusQ & enableQ & EVT_CAP_MASK);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.setMask & IMPL_MASK) != '0) |=>
      ((statusQ & $past(strobes.setMask & IMPL_MASK)) == $past(strobes.setMask & IMPL_MASK))); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrStatus |=> ((statusQ & $past(wrData & ~strobes.setMask)) == '0)); // R2

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusQ) & ~$past(clrMask)) & ~statusQ) == '0)); // R2

endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg
  import wake_pkg::*;
#(
  parameter int BCLK_TIMEOUT = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regAddr,
  input  logic        regWrEn,
  input  logic [9:0]  regWrData,
  output logic [9:0]  regRdData,
  input  logic        ringInN,
  input  logic        smbWakeReq,
  input  logic        tcoSciReq,
  input  logic [1:0]  codecSdin,
  input  logic        codecBitClk,
  input  logic        codecGlobalInt,
  input  logic [1:0]  usbWakeReq,
  input  logic        standbyTimeout,
  input  logic [2:0]  sleepState,
  input  logic        thermPin,
  input  logic        thermPolHigh,
  input  logic        thermOverride,
  output logic        pmEvent
);

  ctrlStrobes_t strobes;

  wake_ctrl #(
    .BCLK_TIMEOUT(BCLK_TIMEOUT),
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .regAddr       (regAddr),
    .regWrEn       (regWrEn),
    .ringInN       (ringInN),
    .smbWakeReq    (smbWakeReq),
    .tcoSciReq     (tcoSciReq),
    .codecSdin     (codecSdin),
    .codecBitClk   (codecBitClk),
    .codecGlobalInt(codecGlobalInt),
    .usbWakeReq    (usbWakeReq),
    .standbyTimeout(standbyTimeout),
    .sleepState    (sleepState),
    .thermPin      (thermPin),
    .thermPolHigh  (thermPolHigh),
    .thermOverride (thermOverride),
    .strobes       (strobes)
  );

  wake_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wrData (regWrData),
    .rdData (regRdData),
    .pmEvent(pmEvent)
  );

endmodule

// File: tb/sim_wake_status_reg.sv
module sim_wake_status_reg;

  localparam int TO = 8;
  localparam logic [9:0] ALL_BITS = 10'h3FB;  // every bit except 2
  localparam logic [9:0] CAP      = 10'h1F9;  // bits 0,3,4,5,6,7,8

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regAddr = 1'b0, regWrEn = 1'b0;
  logic [9:0] regWrData = '0;
  logic [9:0] regRdData;
  logic ringInN = 1'b1, smbWakeReq = 1'b0, tcoSciReq = 1'b0;
  logic [1:0] codecSdin = '0;
  logic codecBitClk = 1'b0, codecGlobalInt = 1'b0;
  logic [1:0] usbWakeReq = '0;
  logic standbyTimeout = 1'b0;
  logic [2:0] sleepState = 3'd0;
  logic thermPin = 1'b0, thermPolHigh = 1'b1, thermOverride = 1'b0;
  logic pmEvent;
  logic bclkRun = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wake_status_reg #(.BCLK_TIMEOUT(TO)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .ringInN(ringInN),
    .smbWakeReq(smbWakeReq), .tcoSciReq(tcoSciReq), .codecSdin(codecSdin),
    .codecBitClk(codecBitClk), .codecGlobalInt(codecGlobalInt),
    .usbWakeReq(usbWakeReq), .standbyTimeout(standbyTimeout),
    .sleepState(sleepState), .thermPin(thermPin), .thermPolHigh(thermPolHigh),
    .thermOverride(thermOverride), .pmEvent(pmEvent)
  );

  // codec bit clock: toggles every two system clocks while running
  initial begin
    forever begin
      repeat (2) @(negedge clk);
      if (bclkRun) codecBitClk = ~codecBitClk;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readReg(input logic a, output logic [9:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic writeReg(input logic a, input logic [9:0] d);
    regAddr = a;
    regWrData = d;
    regWrEn = 1'b1;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic trigger(input int b);
    case (b)
      0: begin ringInN = 1'b0; tick(5); ringInN = 1'b1; tick(4); end
      1: begin smbWakeReq = 1'b1; tick(1); smbWakeReq = 1'b0; end
      3: begin tcoSciReq = 1'b1; tick(1); tcoSciReq = 1'b0; end
      4: begin codecGlobalInt = 1'b1; tick(1); codecGlobalInt = 1'b0; end
      5: begin usbWakeReq = 2'b01; tick(1); usbWakeReq = 2'b00; end
      6: begin usbWakeReq = 2'b10; tick(1); usbWakeReq = 2'b00; end
      7: begin sleepState = 3'd1; standbyTimeout = 1'b1; tick(1);
                standbyTimeout = 1'b0; sleepState = 3'd0; end
      8: begin thermPolHigh = 1'b1; thermPin = 1'b1; tick(5); thermPin = 1'b0; tick(4); end
      9: begin thermOverride = 1'b1; tick(1); thermOverride = 1'b0; end
      default: tick(1);
    endcase
  endtask

  task automatic setAll();
    ringInN = 1'b0; thermPolHigh = 1'b1; thermPin = 1'b1;
    smbWakeReq = 1'b1; tcoSciReq = 1'b1; codecGlobalInt = 1'b1; usbWakeReq = 2'b11;
    sleepState = 3'd1; standbyTimeout = 1'b1; thermOverride = 1'b1;
    tick(1);
    smbWakeReq = 1'b0; tcoSciReq = 1'b0; codecGlobalInt = 1'b0; usbWakeReq = 2'b00;
    standbyTimeout = 1'b0; sleepState = 3'd0; thermOverride = 1'b0;
    tick(4);
    ringInN = 1'b1; thermPin = 1'b0;
    tick(4);
  endtask

  logic [9:0] v;

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);

    // R1 reset state
    readReg(1'b0, v); check("R1 status after reset", v, 0);
    readReg(1'b1, v); check("R1 enable after reset", v, 0);
    check("R1 event after reset", pmEvent, 0);

    // each source alone: its bit and its event-capability
    writeReg(1'b1, 10'h3FF);
    for (int b = 0; b < 10; b++) begin
      if (b == 2) continue;
      writeReg(1'b0, 10'h3FF);
      trigger(b);
      readReg(1'b0, v);
      check($sformatf("R5 R6 R8 R9 R11 source bit %0d", b), v, 10'(1) << b);
      check($sformatf("R12 event for bit %0d", b), pmEvent, CAP[b]);
    end
    writeReg(1'b0, 10'h3FF);

    // R8 lane-specific enables
    writeReg(1'b1, 10'h040);
    trigger(5);
    check("R8 usb0 without its enable", pmEvent, 0);
    writeReg(1'b1, 10'h020);
    check("R8 usb0 with its enable", pmEvent, 1);
    writeReg(1'b0, 10'h3FF);

    // R2 exhaustive clear masks
    for (int m = 0; m < 1024; m++) begin
      setAll();
      writeReg(1'b0, 10'(m));
      readReg(1'b0, v);
      check("R2 write-one-to-clear", v, ALL_BITS & ~10'(m));
    end

    // R12 exhaustive enable words against full status
    setAll();
    for (int e = 0; e < 1024; e++) begin
      writeReg(1'b1, 10'(e));
      readReg(1'b1, v);
      check("R12 R5 R11 enable readback", v, 10'(e) & CAP);
      check("R12 event OR", pmEvent, ((ALL_BITS & 10'(e) & CAP) != 0));
    end
    writeReg(1'b0, 10'h3FF);
    writeReg(1'b1, 10'h3FF);

    // R5 R11: non-capable bits alone never raise the event
    trigger(1); trigger(9);
    check("R5 R11 no event from smb/override", pmEvent, 0);
    writeReg(1'b0, 10'h3FF);

    // R9 sleep-state sweep
    for (int s = 0; s < 8; s++) begin
      sleepState = 3'(s);
      standbyTimeout = 1'b1; tick(1); standbyTimeout = 1'b0;
      readReg(1'b0, v);
      check($sformatf("R9 standby in state %0d", s), v, (s == 1) ? 10'h080 : 10'h000);
      writeReg(1'b0, 10'h3FF);
    end
    sleepState = 3'd0;

    // R3 set beats clear in the same cycle
    tcoSciReq = 1'b1; usbWakeReq = 2'b10;
    writeReg(1'b0, 10'h3FF);
    tcoSciReq = 1'b0; usbWakeReq = 2'b00;
    readReg(1'b0, v);
    check("R3 set wins over clear", v, 10'h048);
    writeReg(1'b0, 10'h3FF);

    // R4 ring held low sets once
    ringInN = 1'b0; tick(5);
    readReg(1'b0, v); check("R4 ring fall sets", v, 10'h001);
    writeReg(1'b0, 10'h001); tick(5);
    readReg(1'b0, v); check("R4 held low no re-set", v, 10'h000);
    ringInN = 1'b1; tick(5);
    readReg(1'b0, v); check("R4 rising edge ignored", v, 10'h000);

    // R10 both polarities, held level
    for (int p = 0; p < 2; p++) begin
      thermPolHigh = p[0]; thermPin = ~p[0]; tick(5);
      writeReg(1'b0, 10'h3FF);
      thermPin = p[0]; tick(5);
      readReg(1'b0, v); check($sformatf("R10 active edge pol %0d", p), v, 10'h100);
      writeReg(1'b0, 10'h3FF); tick(5);
      readReg(1'b0, v); check($sformatf("R10 held active pol %0d", p), v, 10'h000);
      thermPin = ~p[0]; tick(5);
      readReg(1'b0, v); check($sformatf("R10 inactive edge pol %0d", p), v, 10'h000);
    end
    thermPolHigh = 1'b1; thermPin = 1'b0;

    // R7 codec data vs bit-clock activity, each data lane
    for (int lane = 0; lane < 2; lane++) begin
      bclkRun = 1'b1; codecSdin = 2'b00; tick(6);
      writeReg(1'b0, 10'h3FF);
      codecSdin = 2'(1 << lane); tick(4 * TO);
      readReg(1'b0, v); check($sformatf("R7 running clock lane %0d", lane), v, 10'h000);
      bclkRun = 1'b0; tick(3);
      readReg(1'b0, v); check($sformatf("R7 before idle window lane %0d", lane), v, 10'h000);
      tick(TO + 6);
      readReg(1'b0, v); check($sformatf("R7 stopped clock lane %0d", lane), v, 10'h010);
      codecSdin = 2'b00; bclkRun = 1'b1; tick(6);
      writeReg(1'b0, 10'h3FF);
      readReg(1'b0, v); check($sformatf("R7 cleared lane %0d", lane), v, 10'h000);
    end

    summary();
  end

endmodule